// File: doc/BRIEF.md
# Frequency Sweep and Modulation Controller

This block produces the phase-increment word for a numerically controlled oscillator. The whole word is replaced on one clock edge, and it can change on any cycle, so the oscillator never sees a partly updated value. Software-style settings are written through a small load port. A mode select picks one of four behaviours: a fixed tone, a linear chirp, a logarithmic sweep made by shifting a single set bit, or two-tone frequency-shift keying chosen by a data bit.

The controller is a three-state machine. `ST_IDLE` is entered at reset and holds a zero word until the first restart. `ST_RUN` updates the word according to the mode. `ST_HOLD` freezes a linear chirp that has reached its end value with wrapping disabled. The transitions are: IDLE to RUN on restart; RUN to RUN on restart or on any ordinary update; RUN to HOLD when a linear step reaches the end value and wrap is off; HOLD to RUN on restart, or when the mode select leaves linear; HOLD to HOLD while the mode stays linear. The linear and logarithmic update rates come from a shared divider that fires once every (limit + 1) cycles.

Top module: `sweep_ctrl`

## Requirements
- R1: After reset `inc_out` is 0 and `inc_vld` is 0, and the word stays 0 in any mode until `restart` is first asserted.
- R2: Config writes (`cfg_we`=1) at `cfg_addr` 0 start, 1 step, 2 end value, 3 linear divider, 4 log interval, 5 mark, 6 space, 7 wrap flag (bit 0) take effect on the write edge. Mode codes are 0 fixed, 1 linear, 2 log, 3 FSK. In fixed mode the output becomes the start register on the edge after that register changes, with no intermediate value.
- R3: On a `restart` edge the output loads the start value (in FSK mode the word selected by `fsk_bit`) and the rate divider restarts its count from zero.
- R4: In linear mode the word rises by the step value once every (divider + 1) cycles, counted from the restart edge.
- R5: A linear step that would reach or pass the end value leaves the word at the end value. With wrap = 0 the word then holds until restart.
- R6: With wrap = 1, the first linear update after the word has reached the end value reloads the start value, and the sweep continues from there.
- R7: In log mode the word shifts left by one bit once every (interval + 1) cycles, so a single set bit doubles the frequency at each shift.
- R8: In log mode, an update that finds bit W-1 set reloads the start value instead of shifting.
- R9: In FSK mode the word becomes the mark register when `fsk_bit` is 1 and the space register when it is 0, on the first edge that samples the bit, with no other change.
- R10: `inc_vld` is 1 for exactly the cycles in which `inc_out` differs from its value in the previous cycle.
- R11: In HOLD, changing the mode away from linear returns the machine to RUN, and the word follows the new mode on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Config write enable |
| cfg_addr | input | 3 | Config register select |
| cfg_data | input | W | Config write data |
| mode_sel | input | 2 | Mode: 0 fixed, 1 linear, 2 log, 3 FSK |
| restart | input | 1 | Synchronous restart of the sweep |
| fsk_bit | input | 1 | FSK data bit (1 = mark) |
| inc_out | output | W | Phase-increment word |
| inc_vld | output | 1 | Word changed this cycle |

## Verification
Linear chirps are run over every divider value from 0 to 3 and several step sizes, both with wrapping and without it. This separates an off-by-one in the rate count from an error in saturation or reload. Log sweeps start from different single bits and run past the top bit, which exposes a wrong shift rate or a missing reload. An FSK bit pattern with runs and isolated toggles checks that the word follows each bit edge and that the valid strobe rises only on real changes. A restart issued in mid-interval, and a start-register write in fixed mode, show whether the counter is cleared and whether the word changes in a single step.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
    typedef enum logic [1:0] {
        MODE_FIXED = 2'd0,
        MODE_LIN   = 2'd1,
        MODE_LOG   = 2'd2,
        MODE_FSK   = 2'd3
    } sweep_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } sweep_st_e;

    typedef enum logic [2:0] {
        CFG_START = 3'd0,
        CFG_STEP  = 3'd1,
        CFG_STOP  = 3'd2,
        CFG_DIV   = 3'd3,
        CFG_IVL   = 3'd4,
        CFG_MARK  = 3'd5,
        CFG_SPACE = 3'd6,
        CFG_WRAP  = 3'd7
    } cfg_sel_e;
endpackage

// File: rtl/sweep_cfg.sv
module sweep_cfg
    import sweep_pkg::*;
#(
    parameter int W  = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [2:0]    addr,
    input  logic [W-1:0]  data,
    output logic [W-1:0]  start_q,
    output logic [W-1:0]  step_q,
    output logic [W-1:0]  stop_q,
    output logic [CW-1:0] div_q,
    output logic [CW-1:0] ivl_q,
    output logic [W-1:0]  mark_q,
    output logic [W-1:0]  space_q,
    output logic          wrap_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
            step_q  <= '0;
            stop_q  <= '0;
            div_q   <= '0;
            ivl_q   <= '0;
            mark_q  <= '0;
            space_q <= '0;
            wrap_q  <= 1'b0;
        end else if (we) begin
            unique case (cfg_sel_e'(addr))
                CFG_START: start_q <= data;
                CFG_STEP:  step_q  <= data;
                CFG_STOP:  stop_q  <= data;
                CFG_DIV:   div_q   <= data[CW-1:0];
                CFG_IVL:   ivl_q   <= data[CW-1:0];
                CFG_MARK:  mark_q  <= data;
                CFG_SPACE: space_q <= data;
                CFG_WRAP:  wrap_q  <= data[0];
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/sweep_rate.sv
module sweep_rate #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [CW-1:0] limit,
    output logic          tick
);
    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (clr || tick)  cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt_q == '0) || (cnt_q <= $past(limit)));

    // R3
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt_q == '0);
endmodule

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
    import sweep_pkg::*;
#(
    parameter int W  = 32,
    parameter int CW = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_we,
    input  logic [2:0]   cfg_addr,
    input  logic [W-1:0] cfg_data,
    input  logic [1:0]   mode_sel,
    input  logic         restart,
    input  logic         fsk_bit,
    output logic [W-1:0] inc_out,
    output logic         inc_vld
);
    logic [W-1:0]  start_q, step_q, stop_q, mark_q, space_q;
    logic [CW-1:0] div_q, ivl_q, limit;
    logic          wrap_q, tick;
    sweep_mode_e   mode;
    sweep_st_e     st_q, st_d;
    logic [W-1:0]  inc_q, inc_d, run_val, fsel;
    logic [W:0]    sum;
    logic          go_hold;

    sweep_cfg #(.W(W), .CW(CW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .data(cfg_data),
        .start_q(start_q), .step_q(step_q), .stop_q(stop_q), .div_q(div_q),
        .ivl_q(ivl_q), .mark_q(mark_q), .space_q(space_q), .wrap_q(wrap_q)
    );

    assign mode  = sweep_mode_e'(mode_sel);
    assign limit = (mode == MODE_LOG) ? ivl_q : div_q;

    sweep_rate #(.CW(CW)) u_rate (
        .clk(clk), .rst_n(rst_n), .clr(restart), .limit(limit), .tick(tick)
    );

    assign sum  = {1'b0, inc_q} + {1'b0, step_q};
    assign fsel = fsk_bit ? mark_q : space_q;

    // Mode-dependent update of the word while running
    always_comb begin
        run_val = inc_q;
        go_hold = 1'b0;
        unique case (mode)
            MODE_FIXED: run_val = start_q;
            MODE_LIN: begin
                if (tick) begin
                    if (inc_q >= stop_q) begin
                        if (wrap_q) run_val = start_q;
                        else        go_hold = 1'b1;
                    end else if (sum >= {1'b0, stop_q}) begin
                        run_val = stop_q;
                        go_hold = !wrap_q;
                    end else begin
                        run_val = sum[W-1:0];
                    end
                end
            end
            MODE_LOG: begin
                if (tick) run_val = inc_q[W-1] ? start_q : (inc_q << 1);
            end
            MODE_FSK:   run_val = fsel;
            default:    run_val = inc_q;
        endcase
    end

    // Next state and next word
    always_comb begin
        st_d  = st_q;
        inc_d = inc_q;
        if (restart) begin
            st_d  = ST_RUN;
            inc_d = (mode == MODE_FSK) ? fsel : start_q;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    st_d  = ST_IDLE;
                    inc_d = inc_q;
                end
                ST_RUN: begin
                    inc_d = run_val;
                    st_d  = go_hold ? ST_HOLD : ST_RUN;
                end
                ST_HOLD: begin
                    if (mode != MODE_LIN) begin
                        inc_d = run_val;
                        st_d  = ST_RUN;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inc_q   <= '0;
            inc_vld <= 1'b0;
        end else begin
            inc_q   <= inc_d;
            inc_vld <= (inc_d != inc_q);
        end
    end

    assign inc_out = inc_q;

    // R10
    vld_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (inc_vld == (inc_out != $past(inc_out))));

    // R3
    restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && mode != MODE_FSK) |=> inc_out == $past(start_q));

    // R9
    fsk_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FSK && (restart || st_q != ST_IDLE))
        |=> inc_out == ($past(fsk_bit) ? $past(mark_q) : $past(space_q)));

    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD && mode == MODE_LIN && !restart) |=> $stable(inc_out));

    // R4
    lin_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && mode == MODE_LIN && !tick && !restart) |=> $stable(inc_out));

    // R7
    log_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && mode == MODE_LOG && !restart &&
         $countones(start_q) == 1 && $countones(inc_out) == 1)
        |=> $countones(inc_out) == 1);

    // R1
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> inc_out == '0);
endmodule

// File: tb/tb_sweep_ctrl.sv
`timescale 1ns/1ps
module tb_sweep_ctrl;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [2:0]   cfg_addr = '0;
    logic [W-1:0] cfg_data = '0;
    logic [1:0]   mode_sel = 2'd0;
    logic         restart = 1'b0;
    logic         fsk_bit = 1'b0;
    logic [W-1:0] inc_out;
    logic         inc_vld;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [W-1:0] m_start, m_step, m_stop;
    logic         m_wrap;

    sweep_ctrl #(.W(W), .CW(16)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .mode_sel(mode_sel), .restart(restart),
        .fsk_bit(fsk_bit), .inc_out(inc_out), .inc_vld(inc_vld)
    );

    always #4 clk = ~clk;

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
        cyc();
        cfg_we = 1'b0;
        if (a == 3'd0) m_start = d;
        if (a == 3'd1) m_step  = d;
        if (a == 3'd2) m_stop  = d;
        if (a == 3'd7) m_wrap  = d[0];
    endtask

    task automatic pulse_restart();
        restart = 1'b1;
        cyc();
        restart = 1'b0;
    endtask

    function automatic logic [W-1:0] lin_next(input logic [W-1:0] v);
        logic [W:0] s;
        if (v >= m_stop) return m_wrap ? m_start : v;
        s = {1'b0, v} + {1'b0, m_step};
        return (s >= {1'b0, m_stop}) ? m_stop : s[W-1:0];
    endfunction

    // Runs nt updates with period lim+1 and checks each one at its edge
    task automatic run_lin(input int lim, input int nt, input string tag);
        logic [W-1:0] v, nv;
        v = m_start;
        for (int n = 0; n < nt; n++) begin
            if (lim > 0) begin
                repeat (lim) cyc();
                chk({tag, " before update"}, inc_out, v);
            end
            cyc();
            nv = lin_next(v);
            chk({tag, " value"}, inc_out, nv);
            chk("R10 vld", {31'd0, inc_vld}, {31'd0, nv != v});
            v = nv;
        end
    endtask

    initial begin
        m_start = '0; m_step = '0; m_stop = '0; m_wrap = 1'b0;
        repeat (3) cyc();
        chk("R1 reset word", inc_out, '0);
        chk("R1 reset vld", {31'd0, inc_vld}, '0);
        rst_n = 1'b1;
        mode_sel = 2'd1;
        wr(3'd0, 32'd55);
        repeat (4) cyc();
        chk("R1 idle word", inc_out, '0);

        // R4 / R5 linear sweep without wrap, several dividers and steps
        wr(3'd7, 32'd0);
        wr(3'd2, 32'd150);
        for (int lim = 0; lim < 4; lim++) begin
            for (int si = 0; si < 3; si++) begin
                wr(3'd3, lim);
                wr(3'd1, (si == 0) ? 32'd1 : (si == 1) ? 32'd7 : 32'd13);
                wr(3'd0, 32'd100 + si);
                pulse_restart();
                chk("R3 restart load", inc_out, m_start);
                run_lin(lim, 8, "R4 R5 linear");
            end
        end

        // R6 wrap
        wr(3'd7, 32'd1);
        wr(3'd0, 32'd10);
        wr(3'd1, 32'd20);
        wr(3'd2, 32'd60);
        wr(3'd3, 32'd1);
        pulse_restart();
        chk("R6 restart", inc_out, 32'd10);
        run_lin(1, 10, "R6 wrap");

        // R5 hold then R11 leave hold by mode change
        wr(3'd7, 32'd0);
        wr(3'd3, 32'd0);
        pulse_restart();
        run_lin(0, 5, "R5 hold");
        wr(3'd0, 32'd5);
        chk("R5 held at end", inc_out, 32'd60);
        mode_sel = 2'd0;
        cyc();
        chk("R11 exit hold to fixed", inc_out, 32'd5);

        // R2 fixed mode: single-step replacement of the whole word
        wr(3'd0, 32'h1234_5678);
        pulse_restart();
        chk("R2 fixed load", inc_out, 32'h1234_5678);
        wr(3'd0, 32'hEDCB_A987);
        chk("R2 old word on write edge", inc_out, 32'h1234_5678);
        cyc();
        chk("R2 new word", inc_out, 32'hEDCB_A987);
        chk("R2 vld", {31'd0, inc_vld}, 32'd1);
        cyc();
        chk("R10 vld drop", {31'd0, inc_vld}, 32'd0);

        // R3 restart clears the divider count
        mode_sel = 2'd1;
        wr(3'd0, 32'd0); wr(3'd1, 32'd1); wr(3'd2, 32'd1000); wr(3'd3, 32'd3);
        pulse_restart();
        repeat (2) cyc();
        pulse_restart();
        repeat (3) cyc();
        chk("R3 count cleared", inc_out, 32'd0);
        cyc();
        chk("R3 first step after restart", inc_out, 32'd1);

        // R7 / R8 log sweep from two start bits and two intervals
        mode_sel = 2'd2;
        for (int c = 0; c < 2; c++) begin
            logic [W-1:0] v;
            wr(3'd4, (c == 0) ? 32'd2 : 32'd0);
            wr(3'd0, (c == 0) ? 32'd1 : 32'd8);
            pulse_restart();
            v = m_start;
            for (int k = 0; k < 34; k++) begin
                if (c == 0) begin
                    repeat (2) cyc();
                    chk("R7 log before shift", inc_out, v);
                end
                cyc();
                v = v[W-1] ? m_start : (v << 1);
                chk(v == m_start ? "R8 log reload" : "R7 log shift", inc_out, v);
            end
        end

        // R9 FSK pattern
        mode_sel = 2'd3;
        wr(3'd5, 32'hAAAA_0001);
        wr(3'd6, 32'h0000_BEEF);
        fsk_bit = 1'b0;
        pulse_restart();
        chk("R9 restart space", inc_out, 32'h0000_BEEF);
        begin
            logic [15:0] pat;
            logic        prev;
            pat  = 16'hB2C5;
            prev = 1'b0;
            for (int i = 0; i < 16; i++) begin
                fsk_bit = pat[i];
                cyc();
                chk("R9 fsk word", inc_out, pat[i] ? 32'hAAAA_0001 : 32'h0000_BEEF);
                chk("R10 fsk vld", {31'd0, inc_vld}, {31'd0, pat[i] != prev});
                prev = pat[i];
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule